// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Checker

This block sits at the issue stage of an in-order, dual-issue integer core. Each cycle it receives two candidate instructions in program order, slot 0 before slot 1. Each candidate carries a valid bit and a class code. The block decides in the same cycle whether slot 0 issues, and whether slot 1 issues alongside it. It only considers structural resources: two data pipes with stages E1, E2 and a writeback slot each, multiplier stages M1 and M2, one load/store pipe, one floating-point pipe, a branch unit and a branch-issue resource.

The block keeps a reservation table that covers the current cycle and the following cycles. Each instruction class maps to a fixed pattern of resources over successive cycles. A candidate issues only if its pattern does not collide with the table. A collision is an overlap on any resource. The load/store pipe and the floating-point pipe also exclude each other in the same cycle. For the instructions that issue, the block merges their patterns into the table, and the table then advances by one slot. For data-processing classes the block also reports which data pipe it chose. It tries pipe 0 first and falls back to pipe 1.

Top module: `dual_issue_hazard_chk`

## Requirements
- R1: While reset is held, the reservation table is empty. After reset the next candidate issues as if no resource were busy: two plain ALU ops both issue, slot 0 on pipe 0 and slot 1 on pipe 1.
- R2: The plain ALU op (code 0) and the move with a shifted operand (code 2) reserve E2 of one pipe in the issue cycle and that pipe's writeback one cycle later. Pipe 0 is taken unless it collides and pipe 1 does not. The chosen pipe appears on pipeN_o (0 = pipe 0, 1 = pipe 1). pipeN_o is 0 whenever slot N does not issue or its class is not a data-processing class.
- R3: The shifting ALU op (code 1) reserves E1, then E2, then writeback of one chosen pipe on three consecutive cycles.
- R4: The load/store pipe and the floating-point pipe are never both reserved in one cycle. A candidate needing one of them collides with a cycle that holds the other. The one exception is a call, which holds both itself in its issue cycle.
- R5: A single load (code 3) or single store (code 5) holds the load/store pipe for one cycle. A load multiple (code 4) holds it for two cycles. A store multiple (code 6) holds it for two cycles, with E2 of one chosen pipe in the first cycle and that pipe's writeback in the second.
- R6: The 16x16 multiply (code 7) reserves M1, then M2, then pipe-0 writeback. The 32-bit multiply (code 8) reserves M1 for two cycles, then M2, then pipe-0 writeback.
- R7: The 16x16 multiply-accumulate (code 9) reserves M1, M2 and E1 and E2 of both pipes in its first cycle, then M2, then pipe-0 writeback. The 32-bit multiply-accumulate (code 10) holds that first-cycle set for two cycles, then M2, then pipe-0 writeback.
- R8: A branch (code 11) holds the branch unit for one cycle. A call (code 12) reserves the branch-issue resource, M1, M2, E1 and E2 of both pipes, the load/store pipe and the floating-point pipe in its issue cycle. Slot 1 never issues when either slot holds a call.
- R9: The floating-point pipe is held 1 cycle by code 13 (short operations and single-precision multiply), 2 cycles by code 14 (double-precision multiply or multiply-accumulate), 10 cycles by code 15 (single-precision divide) and 20 cycles by code 16 (double-precision divide).
- R10: Slot 0 issues when it is valid and collision-free. Slot 1 issues only if slot 0 issues and slot 1's pattern does not collide with the table after slot 0's pattern is merged in.
- R11: Each cycle the table advances by one slot and takes in the patterns of the instructions that issued. An invalid candidate reserves nothing, so a busy resource frees exactly when its last reserved cycle has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid0_i | input | 1 | Slot 0 candidate present |
| cls0_i | input | 5 | Slot 0 class code |
| valid1_i | input | 1 | Slot 1 candidate present |
| cls1_i | input | 5 | Slot 1 class code |
| issue0_o | output | 1 | Slot 0 issues this cycle |
| issue1_o | output | 1 | Slot 1 issues this cycle |
| pipe0_o | output | 1 | Data pipe chosen for slot 0 |
| pipe1_o | output | 1 | Data pipe chosen for slot 1 |

## Verification
The assertions assume that class codes stay within 0 to 16. They also assume that the reservation depth covers the longest pattern, which is the 20-cycle double divide. The stimulus draws class codes only from that range. Valid bits are drawn independently, so slot 1 is often offered while slot 0 is empty. The directed sequences stack long floating-point holds, multiplier overlaps and calls against following candidates, so that both exclusion and pipe fallback are exercised.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int NRES  = 12;
  localparam int CLS_W = 5;

  // resource bit positions inside one table slot
  localparam int RS_P0E1 = 0;
  localparam int RS_P0E2 = 1;
  localparam int RS_P1E1 = 2;
  localparam int RS_P1E2 = 3;
  localparam int RS_P0WB = 4;
  localparam int RS_P1WB = 5;
  localparam int RS_M1   = 6;
  localparam int RS_M2   = 7;
  localparam int RS_LS   = 8;
  localparam int RS_FP   = 9;
  localparam int RS_BRU  = 10;
  localparam int RS_BRI  = 11;

  typedef enum logic [CLS_W-1:0] {
    C_ALU    = 5'd0,
    C_ALU_SH = 5'd1,
    C_MOV_SH = 5'd2,
    C_LD     = 5'd3,
    C_LDM    = 5'd4,
    C_ST     = 5'd5,
    C_STM    = 5'd6,
    C_MUL16  = 5'd7,
    C_MUL32  = 5'd8,
    C_MAC16  = 5'd9,
    C_MAC32  = 5'd10,
    C_BR     = 5'd11,
    C_CALL   = 5'd12,
    C_FP1    = 5'd13,
    C_FP2    = 5'd14,
    C_FDIVS  = 5'd15,
    C_FDIVD  = 5'd16
  } cls_e;

  function automatic logic is_dp(input logic [CLS_W-1:0] c);
    return (c == C_ALU) || (c == C_ALU_SH) || (c == C_MOV_SH) || (c == C_STM);
  endfunction

endpackage

// File: rtl/hzd_pattern_gen.sv
module hzd_pattern_gen
  import hzd_pkg::*;
#(
  parameter int DEPTH     = 21,
  parameter int FDIVS_CYC = 10,
  parameter int FDIVD_CYC = 20
) (
  input  logic [CLS_W-1:0]            cls_i,
  input  logic                        alt_pipe_i,
  output logic [DEPTH-1:0][NRES-1:0]  pat_o
);

  logic [NRES-1:0] mc_set;
  int unsigned r_e1, r_e2, r_wb;

  always_comb begin
    mc_set = '0;
    mc_set[RS_M1]   = 1'b1;
    mc_set[RS_M2]   = 1'b1;
    mc_set[RS_P0E1] = 1'b1;
    mc_set[RS_P0E2] = 1'b1;
    mc_set[RS_P1E1] = 1'b1;
    mc_set[RS_P1E2] = 1'b1;
  end

  always_comb begin
    r_e1 = alt_pipe_i ? RS_P1E1 : RS_P0E1;
    r_e2 = alt_pipe_i ? RS_P1E2 : RS_P0E2;
    r_wb = alt_pipe_i ? RS_P1WB : RS_P0WB;
  end

  always_comb begin
    pat_o = '0;
    case (cls_e'(cls_i))
      C_ALU, C_MOV_SH: begin
        pat_o[0][r_e2] = 1'b1;
        pat_o[1][r_wb] = 1'b1;
      end
      C_ALU_SH: begin
        pat_o[0][r_e1] = 1'b1;
        pat_o[1][r_e2] = 1'b1;
        pat_o[2][r_wb] = 1'b1;
      end
      C_LD, C_ST: pat_o[0][RS_LS] = 1'b1;
      C_LDM: begin
        pat_o[0][RS_LS] = 1'b1;
        pat_o[1][RS_LS] = 1'b1;
      end
      C_STM: begin
        pat_o[0][RS_LS] = 1'b1;
        pat_o[0][r_e2]  = 1'b1;
        pat_o[1][RS_LS] = 1'b1;
        pat_o[1][r_wb]  = 1'b1;
      end
      C_MUL16: begin
        pat_o[0][RS_M1]   = 1'b1;
        pat_o[1][RS_M2]   = 1'b1;
        pat_o[2][RS_P0WB] = 1'b1;
      end
      C_MUL32: begin
        pat_o[0][RS_M1]   = 1'b1;
        pat_o[1][RS_M1]   = 1'b1;
        pat_o[2][RS_M2]   = 1'b1;
        pat_o[3][RS_P0WB] = 1'b1;
      end
      C_MAC16: begin
        pat_o[0]          = mc_set;
        pat_o[1][RS_M2]   = 1'b1;
        pat_o[2][RS_P0WB] = 1'b1;
      end
      C_MAC32: begin
        pat_o[0]          = mc_set;
        pat_o[1]          = mc_set;
        pat_o[2][RS_M2]   = 1'b1;
        pat_o[3][RS_P0WB] = 1'b1;
      end
      C_BR: pat_o[0][RS_BRU] = 1'b1;
      C_CALL: begin
        pat_o[0]         = mc_set;
        pat_o[0][RS_BRI] = 1'b1;
        pat_o[0][RS_LS]  = 1'b1;
        pat_o[0][RS_FP]  = 1'b1;
      end
      C_FP1: pat_o[0][RS_FP] = 1'b1;
      C_FP2: begin
        pat_o[0][RS_FP] = 1'b1;
        pat_o[1][RS_FP] = 1'b1;
      end
      C_FDIVS: for (int k = 0; k < DEPTH; k++) if (k < FDIVS_CYC) pat_o[k][RS_FP] = 1'b1;
      C_FDIVD: for (int k = 0; k < DEPTH; k++) if (k < FDIVD_CYC) pat_o[k][RS_FP] = 1'b1;
      default: pat_o = '0;
    endcase
  end

endmodule

// File: rtl/hzd_slot_check.sv
module hzd_slot_check
  import hzd_pkg::*;
#(
  parameter int DEPTH     = 21,
  parameter int FDIVS_CYC = 10,
  parameter int FDIVD_CYC = 20
) (
  input  logic [CLS_W-1:0]            cls_i,
  input  logic [DEPTH-1:0][NRES-1:0]  busy_i,
  output logic                        ok_o,
  output logic                        pipe_o,
  output logic [DEPTH-1:0][NRES-1:0]  pat_o
);

  logic [1:0][DEPTH-1:0][NRES-1:0] cand;
  logic [1:0]                      hit;

  function automatic logic collide(input logic [DEPTH-1:0][NRES-1:0] c,
                                   input logic [DEPTH-1:0][NRES-1:0] b);
    logic h;
    h = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      h |= |(c[k] & b[k]);
      // load/store and floating point exclude each other
      h |= c[k][RS_LS] & b[k][RS_FP];
      h |= c[k][RS_FP] & b[k][RS_LS];
    end
    return h;
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_pipe
    hzd_pattern_gen #(
      .DEPTH    (DEPTH),
      .FDIVS_CYC(FDIVS_CYC),
      .FDIVD_CYC(FDIVD_CYC)
    ) u_gen (
      .cls_i     (cls_i),
      .alt_pipe_i(g == 1),
      .pat_o     (cand[g])
    );
    assign hit[g] = collide(cand[g], busy_i);
  end

  always_comb begin
    pipe_o = is_dp(cls_i) & hit[0] & ~hit[1];
    ok_o   = ~hit[0] | pipe_o;
    pat_o  = pipe_o ? cand[1] : cand[0];
  end

endmodule

// File: rtl/hzd_resv_table.sv
module hzd_resv_table
  import hzd_pkg::*;
#(
  parameter int DEPTH = 21
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DEPTH-1:1][NRES-1:0]  add_i,
  output logic [DEPTH-1:0][NRES-1:0]  tbl_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_o <= '0;
    end else begin
      for (int k = 0; k < DEPTH-1; k++) tbl_o[k] <= tbl_o[k+1] | add_i[k+1];
      tbl_o[DEPTH-1] <= '0;
    end
  end

endmodule

// File: rtl/dual_issue_hazard_chk.sv
module dual_issue_hazard_chk
  import hzd_pkg::*;
#(
  parameter int DEPTH     = 21,
  parameter int FDIVS_CYC = 10,
  parameter int FDIVD_CYC = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid0_i,
  input  logic [CLS_W-1:0] cls0_i,
  input  logic             valid1_i,
  input  logic [CLS_W-1:0] cls1_i,
  output logic             issue0_o,
  output logic             issue1_o,
  output logic             pipe0_o,
  output logic             pipe1_o
);

  logic [DEPTH-1:0][NRES-1:0] tbl_q;
  logic [DEPTH-1:0][NRES-1:0] busy1;
  logic [DEPTH-1:0][NRES-1:0] pat0, pat1;
  logic [DEPTH-1:1][NRES-1:0] commit;
  logic [NRES-1:0]            cur_use;
  logic                       ok0, ok1, pch0, pch1, no_call;

  hzd_slot_check #(
    .DEPTH(DEPTH), .FDIVS_CYC(FDIVS_CYC), .FDIVD_CYC(FDIVD_CYC)
  ) u_chk0 (
    .cls_i (cls0_i),
    .busy_i(tbl_q),
    .ok_o  (ok0),
    .pipe_o(pch0),
    .pat_o (pat0)
  );

  always_comb begin
    for (int k = 0; k < DEPTH; k++) busy1[k] = tbl_q[k] | (issue0_o ? pat0[k] : '0);
  end

  hzd_slot_check #(
    .DEPTH(DEPTH), .FDIVS_CYC(FDIVS_CYC), .FDIVD_CYC(FDIVD_CYC)
  ) u_chk1 (
    .cls_i (cls1_i),
    .busy_i(busy1),
    .ok_o  (ok1),
    .pipe_o(pch1),
    .pat_o (pat1)
  );

  assign no_call  = (cls0_i != C_CALL) && (cls1_i != C_CALL);
  assign issue0_o = valid0_i & ok0;
  assign issue1_o = issue0_o & valid1_i & ok1 & no_call;
  assign pipe0_o  = issue0_o & pch0;
  assign pipe1_o  = issue1_o & pch1;

  always_comb begin
    for (int k = 1; k < DEPTH; k++)
      commit[k] = (issue0_o ? pat0[k] : '0) | (issue1_o ? pat1[k] : '0);
    cur_use = (issue0_o ? pat0[0] : '0) | (issue1_o ? pat1[0] : '0);
  end

  hzd_resv_table #(.DEPTH(DEPTH)) u_tbl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .add_i (commit),
    .tbl_o (tbl_q)
  );

endmodule

// File: rtl/hzd_checker.sv
module hzd_checker
  import hzd_pkg::*;
#(
  parameter int DEPTH     = 21,
  parameter int FDIVD_CYC = 20
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [CLS_W-1:0]           cls0_i,
  input logic [CLS_W-1:0]           cls1_i,
  input logic                       issue0_i,
  input logic                       issue1_i,
  input logic                       pipe0_i,
  input logic                       pipe1_i,
  input logic [DEPTH-1:0][NRES-1:0] tbl_i,
  input logic [NRES-1:0]            cur_i
);

  logic [DEPTH-1:0] ls_fp;
  logic             both_alu;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) ls_fp[k] = tbl_i[k][RS_LS] & tbl_i[k][RS_FP];
    both_alu = (cls0_i == C_ALU) && (cls1_i == C_ALU);
  end

  p_slot1_after_slot0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_i |-> issue0_i);

  p_call_alone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue0_i && cls0_i == C_CALL) |-> !issue1_i);

  p_ls_fp_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_fp == '0);

  p_cur_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i[RS_LS] && cur_i[RS_FP]) |-> cur_i[RS_BRI]);

  p_no_double_book_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i & tbl_i[0]) == '0);

  p_idle_shift_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue0_i && !issue1_i) |=> tbl_i[0] == $past(tbl_i[1]));

  p_alu_pair_split_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue0_i && issue1_i && both_alu) |-> pipe0_i != pipe1_i);

  p_fdivd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue0_i && cls0_i == C_FDIVD) |=> tbl_i[FDIVD_CYC-2][RS_FP]);

endmodule

bind dual_issue_hazard_chk hzd_checker #(
  .DEPTH    (DEPTH),
  .FDIVD_CYC(FDIVD_CYC)
) u_hzd_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cls0_i  (cls0_i),
  .cls1_i  (cls1_i),
  .issue0_i(issue0_o),
  .issue1_i(issue1_o),
  .pipe0_i (pipe0_o),
  .pipe1_i (pipe1_o),
  .tbl_i   (tbl_q),
  .cur_i   (cur_use)
);

// File: tb/test_dual_issue_hazard_chk.sv
`timescale 1ns/1ps
module test_dual_issue_hazard_chk;

  localparam int D = 21;
  localparam int NR = 12;
  // bench-local resource numbering
  localparam int E1A = 0, E2A = 1, E1B = 2, E2B = 3, WBA = 4, WBB = 5;
  localparam int MM1 = 6, MM2 = 7, LSU = 8, FPU = 9, BRU = 10, BRI = 11;

  typedef bit [D-1:0][NR-1:0] pat_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v0 = 1'b0, v1 = 1'b0;
  logic [4:0] c0 = '0, c1 = '0;
  logic       is0, is1, pp0, pp1;

  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  pat_t mtbl;

  always #2.5 clk = ~clk;

  dual_issue_hazard_chk i_dual_issue_hazard_chk (
    .clk_i(clk), .rst_ni(rst_n),
    .valid0_i(v0), .cls0_i(c0), .valid1_i(v1), .cls1_i(c1),
    .issue0_o(is0), .issue1_o(is1), .pipe0_o(pp0), .pipe1_o(pp1)
  );

  function automatic pat_t mpat(input int c, input bit alt);
    pat_t p;
    int e1, e2, wb;
    bit [NR-1:0] mc;
    p = '0;
    e1 = alt ? E1B : E1A; e2 = alt ? E2B : E2A; wb = alt ? WBB : WBA;
    mc = '0;
    mc[MM1] = 1; mc[MM2] = 1; mc[E1A] = 1; mc[E2A] = 1; mc[E1B] = 1; mc[E2B] = 1;
    case (c)
      0, 2: begin p[0][e2] = 1; p[1][wb] = 1; end
      1: begin p[0][e1] = 1; p[1][e2] = 1; p[2][wb] = 1; end
      3, 5: p[0][LSU] = 1;
      4: begin p[0][LSU] = 1; p[1][LSU] = 1; end
      6: begin p[0][LSU] = 1; p[0][e2] = 1; p[1][LSU] = 1; p[1][wb] = 1; end
      7: begin p[0][MM1] = 1; p[1][MM2] = 1; p[2][WBA] = 1; end
      8: begin p[0][MM1] = 1; p[1][MM1] = 1; p[2][MM2] = 1; p[3][WBA] = 1; end
      9: begin p[0] = mc; p[1][MM2] = 1; p[2][WBA] = 1; end
      10: begin p[0] = mc; p[1] = mc; p[2][MM2] = 1; p[3][WBA] = 1; end
      11: p[0][BRU] = 1;
      12: begin p[0] = mc; p[0][BRI] = 1; p[0][LSU] = 1; p[0][FPU] = 1; end
      13: p[0][FPU] = 1;
      14: begin p[0][FPU] = 1; p[1][FPU] = 1; end
      15: for (int k = 0; k < 10; k++) p[k][FPU] = 1;
      16: for (int k = 0; k < 20; k++) p[k][FPU] = 1;
      default: p = '0;
    endcase
    return p;
  endfunction

  function automatic bit mhit(input pat_t a, input pat_t b);
    bit h = 0;
    for (int k = 0; k < D; k++)
      h |= (|(a[k] & b[k])) | (a[k][LSU] & b[k][FPU]) | (a[k][FPU] & b[k][LSU]);
    return h;
  endfunction

  function automatic bit mdp(input int c);
    return c == 0 || c == 1 || c == 2 || c == 6;
  endfunction

  function automatic string req_of(input int c);
    case (c)
      0, 2: return "R2";
      1: return "R3";
      3, 4, 5, 6: return "R5";
      7, 8: return "R6";
      9, 10: return "R7";
      11, 12: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic slot(input int c, input pat_t b, output bit ok, output bit pch, output pat_t p);
    bit h0, h1;
    h0 = mhit(mpat(c, 0), b);
    h1 = mhit(mpat(c, 1), b);
    pch = mdp(c) && h0 && !h1;
    ok = !h0 || pch;
    p = mpat(c, pch);
  endtask

  // drive at negedge, compare before the next posedge, then advance the model
  task automatic step(input bit a0, input int k0, input bit a1, input int k1, input string tag);
    bit ok0, ok1, ch0, ch1, ei0, ei1;
    pat_t p0, p1, b1;
    @(negedge clk);
    v0 = a0; c0 = 5'(k0); v1 = a1; c1 = 5'(k1);
    #1;
    slot(k0, mtbl, ok0, ch0, p0);
    ei0 = a0 && ok0;
    b1 = ei0 ? (mtbl | p0) : mtbl;
    slot(k1, b1, ok1, ch1, p1);
    ei1 = ei0 && a1 && ok1 && k0 != 12 && k1 != 12;
    chk(tag, "issue0", is0, ei0);
    chk((tag == "") ? "R10" : tag, "issue1", is1, ei1);
    chk(tag, "pipe0", pp0, ei0 && ch0);
    chk(tag, "pipe1", pp1, ei1 && ch1);
    if (!ei0) p0 = '0;
    if (!ei1) p1 = '0;
    for (int k = 0; k < D-1; k++) mtbl[k] = mtbl[k+1] | p0[k+1] | p1[k+1];
    mtbl[D-1] = '0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; v0 = 0; v1 = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mtbl = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mtbl = '0;
    do_reset();
    // R1: empty after reset, ALU pair splits over both pipes
    step(1, 0, 1, 0, "R1");
    chk("R1", "pipe1 literal", pp1, 1'b1);
    idle(3, "R11");
    // R3: two shifting ops hold E2 of both pipes next cycle
    step(1, 1, 1, 1, "R3");
    step(1, 0, 1, 0, "R3");
    chk("R3", "alu blocked by E2", is0, 1'b0);
    step(1, 0, 1, 2, "R2");
    idle(3, "R11");
    // R4: divide holds FP for 10 cycles, loads collide with it
    step(1, 15, 1, 3, "R4");
    for (int i = 0; i < 11; i++) step(1, 3, 1, 13, "R4");
    idle(2, "R11");
    // R5: load multiple then single load
    step(1, 4, 1, 3, "R5");
    step(1, 3, 1, 5, "R5");
    step(1, 6, 1, 6, "R5");
    step(1, 6, 1, 0, "R5");
    idle(3, "R11");
    // R6: multiplier M1 overlap
    step(1, 8, 1, 7, "R6");
    step(1, 7, 1, 0, "R6");
    step(1, 7, 1, 8, "R6");
    idle(4, "R11");
    // R7: MAC blocks ALU pairing
    step(1, 9, 1, 0, "R7");
    step(1, 10, 1, 1, "R7");
    step(1, 0, 1, 0, "R7");
    idle(4, "R11");
    // R8: calls and branches
    step(1, 12, 1, 11, "R8");
    chk("R8", "call pair literal", is1, 1'b0);
    step(1, 11, 1, 11, "R8");
    step(1, 11, 1, 12, "R8");
    idle(2, "R11");
    // R9: double divide holds FP for 20 cycles
    step(1, 16, 0, 0, "R9");
    for (int i = 0; i < 21; i++) step(1, 13, 1, 14, "R9");
    idle(2, "R11");
    // R10: slot1 alone never issues
    step(0, 0, 1, 0, "R10");
    step(0, 3, 1, 3, "R10");
    // reset mid-stream clears pending reservations
    step(1, 16, 1, 0, "R9");
    do_reset();
    step(1, 13, 1, 3, "R1");
    idle(2, "R11");
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int k0, k1;
      bit a0, a1;
      k0 = $urandom_range(0, 16);
      k1 = $urandom_range(0, 16);
      if (k0 >= 15 && $urandom_range(0, 3) != 0) k0 = $urandom_range(0, 11);
      a0 = $urandom_range(0, 4) != 0;
      a1 = $urandom_range(0, 4) != 0;
      step(a0, k0, a1, k1, req_of(k0));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule